// File: doc/BRIEF.md
# Field Image Address Sequencer

This block walks a planar Y, U and V image held in memory and issues one word read request per 32-bit word, line by line, for one video field at a time. Each line is fetched as all of its luma words, then all of its U words, then all of its V words. Every plane keeps its own line start address. At the end of each line, that start address advances by the plane's own 16-bit unsigned stride. The next field restarts every plane from its base address.

A processor hands over the pointers for the next field as base addresses and strides, followed by a one-cycle load strobe. These pointers are held in a shadow set and take effect when the next field starts. If no load arrives between two field starts, an underrun is recorded and the previous pointers are used again. Three sticky events report progress:

- a programmable completed-line count has been reached;
- the field has been fully requested;
- an underrun has occurred.

The first two can raise an interrupt through individual enables. A byte-lane order output tells the downstream unpacker whether the words of the current field are big-endian or little-endian.

Top module: `field_addr_seq`

## Requirements
- R1: After `rst_n` low, or a cycle with `soft_rst` high, `req_valid` is 0 and all three flags are 0. A pending pointer load is discarded, so the next field start counts as an underrun.
- R2: An accepted field start makes `req_valid` high from the following cycle. Each line issues Y words, then U words, then V words, with `req_plane` coded 0 for Y, 1 for U and 2 for V. Word k of a plane's line is at that line's start address plus 4k. Y needs ceil(`y_width`/4) words and U and V each need ceil(`c_width`/4) words; a width of 0 counts as one word.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_plane` hold their values.
- R4: Line 0 of a plane starts at its base. Each following line starts at the previous start plus the zero-extended 16-bit stride, modulo 2^AW.
- R5: `ptr_load` captures the three bases and three strides. They apply from the next accepted field start, and a load during a field leaves that field's addresses unchanged.
- R6: A field start with no `ptr_load` since the previous accepted field start sets `flag_urun` and reuses the previous pointers.
- R7: `flag_ytr` is set at the edge that accepts the last V word of the line whose completed-line count equals `y_thresh`. A threshold of 0 never sets it.
- R8: When the completed-line count reaches `img_height`, `flag_empty` is set at that same edge and `req_valid` drops.
- R9: Flags stay set until a 1 is written to their clear bit in `flag_clr` (bit 0 ytr, bit 1 empty, bit 2 urun). A set event in the same cycle wins over the clear.
- R10: `irq` is high exactly when (`flag_ytr` and `irq_en[0]`) or (`flag_empty` and `irq_en[1]`).
- R11: `lane_le` takes the value of `le_sel` at the accepted field start and holds it for the field, where 1 means little-endian and 0 means big-endian.
- R12: `fld_start` while a field is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of counters and flags |
| fld_start | input | 1 | Field start pulse |
| ptr_load | input | 1 | New pointers are present on the base and stride inputs |
| y_base | input | AW | Luma base byte address |
| u_base | input | AW | U base byte address |
| v_base | input | AW | V base byte address |
| y_stride | input | 16 | Luma line stride |
| u_stride | input | 16 | U line stride |
| v_stride | input | 16 | V line stride |
| img_height | input | LW | Lines per field |
| y_width | input | WW | Luma samples per line |
| c_width | input | WW | Chroma samples per line |
| y_thresh | input | LW | Completed-line count that sets the threshold flag |
| le_sel | input | 1 | 1 selects little-endian lanes |
| flag_clr | input | 3 | Write-one-to-clear strobes |
| irq_en | input | 2 | Interrupt enables for ytr and empty |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | AW | Byte address of the requested word |
| req_plane | output | 2 | Plane of the request |
| lane_le | output | 1 | Byte-lane order for the current field |
| flag_ytr | output | 1 | Line threshold reached |
| flag_empty | output | 1 | Field fully requested |
| flag_urun | output | 1 | Pointer underrun |
| irq | output | 1 | Combined interrupt |

## Verification
A request becomes visible in the cycle after the edge that accepts the field start. Its address and plane are compared at the falling edge before the rising edge that accepts it, because that is when `req_ready` is being offered. The threshold and empty flags belong to the edge that accepts the last V word of a line, so they are checked at the next falling edge. `flag_urun` and `lane_le` are checked at the falling edge right after the start pulse. `irq` follows the flags within the same cycle, and a clear strobe shows one falling edge later. The stimulus is changed only at falling edges, which keeps every sample half a period away from the edge that produced it.

// File: rtl/fas_pkg.sv
package fas_pkg;
    localparam int NPLANE = 3;
    localparam int STRW   = 16;

    localparam logic [1:0] PL_Y = 2'd0;
    localparam logic [1:0] PL_U = 2'd1;
    localparam logic [1:0] PL_V = 2'd2;

    localparam int FL_YTR   = 0;
    localparam int FL_EMPTY = 1;
    localparam int FL_URUN  = 2;
    localparam int NFLAG    = 3;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } wk_state_e;
endpackage

// File: rtl/fas_ptr_bank.sv
module fas_ptr_bank
    import fas_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          ptr_load,
    input  logic                          field_go,
    input  logic [NPLANE-1:0][AW-1:0]     base_in,
    input  logic [NPLANE-1:0][STRW-1:0]   stride_in,
    output logic [NPLANE-1:0][AW-1:0]     sel_base,
    output logic [NPLANE-1:0][STRW-1:0]   act_stride,
    output logic                          urun_evt
);
    typedef struct packed {
        logic [NPLANE-1:0][AW-1:0]   sh_base;
        logic [NPLANE-1:0][AW-1:0]   act_base;
        logic [NPLANE-1:0][STRW-1:0] sh_str;
        logic [NPLANE-1:0][STRW-1:0] act_str;
        logic                        pend;
    } bank_t;

    bank_t bank_q, bank_d;

    // Next state: a field start consumes the pending shadow set,
    // a load in the same cycle refills the shadow for the field after.
    always_comb begin
        bank_d   = bank_q;
        urun_evt = 1'b0;
        if (field_go) begin
            urun_evt = !bank_q.pend;
            if (bank_q.pend) begin
                bank_d.act_base = bank_q.sh_base;
                bank_d.act_str  = bank_q.sh_str;
            end
            bank_d.pend = 1'b0;
        end
        if (ptr_load) begin
            bank_d.sh_base = base_in;
            bank_d.sh_str  = stride_in;
            bank_d.pend    = 1'b1;
        end
        if (soft_rst) begin
            bank_d.pend = 1'b0;
            urun_evt    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sel_base   = bank_q.pend ? bank_q.sh_base : bank_q.act_base;
    assign act_stride = bank_q.act_str;
endmodule

// File: rtl/fas_walker.sv
module fas_walker
    import fas_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 11,
    parameter int WW = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          field_go,
    input  logic                          le_sel,
    input  logic [NPLANE-1:0][AW-1:0]     sel_base,
    input  logic [NPLANE-1:0][STRW-1:0]   act_stride,
    input  logic [LW-1:0]                 height,
    input  logic [LW-1:0]                 y_thresh,
    input  logic [WW-1:0]                 y_width,
    input  logic [WW-1:0]                 c_width,
    input  logic                          req_ready,
    output logic                          busy,
    output logic                          req_valid,
    output logic [AW-1:0]                 req_addr,
    output logic [1:0]                    req_plane,
    output logic                          lane_le,
    output logic                          ytr_evt,
    output logic                          empty_evt
);
    localparam int WCW = WW - 1;

    typedef struct packed {
        wk_state_e                 st;
        logic [1:0]                plane;
        logic [WCW-1:0]            word;
        logic [LW-1:0]             line;
        logic                      le;
        logic [NPLANE-1:0][AW-1:0] lstart;
    } wk_t;

    wk_t wk_q, wk_d;

    logic [WCW-1:0] y_words;
    logic [WCW-1:0] c_words;
    logic [WCW-1:0] cur_words;
    logic [LW-1:0]  line_nx;
    logic [AW-1:0]  cur_start;

    function automatic logic [WCW-1:0] words_of(input logic [WW-1:0] w);
        logic [WW:0] t;
        t = ({1'b0, w} + (WW+1)'(3)) >> 2;
        if (t == '0) begin
            t = (WW+1)'(1);
        end
        return t[WCW-1:0];
    endfunction

    always_comb begin
        y_words   = words_of(y_width);
        c_words   = words_of(c_width);
        cur_words = (wk_q.plane == PL_Y) ? y_words : c_words;
        line_nx   = wk_q.line + 1'b1;
        cur_start = wk_q.lstart[wk_q.plane];
    end

    // Next state: word within plane, plane within line, line within field.
    always_comb begin
        wk_d      = wk_q;
        ytr_evt   = 1'b0;
        empty_evt = 1'b0;
        unique case (wk_q.st)
            WK_IDLE: begin
                if (field_go) begin
                    wk_d.st     = WK_RUN;
                    wk_d.plane  = PL_Y;
                    wk_d.word   = '0;
                    wk_d.line   = '0;
                    wk_d.le     = le_sel;
                    wk_d.lstart = sel_base;
                end
            end
            WK_RUN: begin
                if (req_ready) begin
                    if (wk_q.word == cur_words - 1'b1) begin
                        wk_d.word = '0;
                        if (wk_q.plane == PL_V) begin
                            wk_d.plane = PL_Y;
                            wk_d.line  = line_nx;
                            for (int p = 0; p < NPLANE; p++) begin
                                wk_d.lstart[p] = wk_q.lstart[p] + AW'(act_stride[p]);
                            end
                            if (line_nx == y_thresh) begin
                                ytr_evt = 1'b1;
                            end
                            if (line_nx == height) begin
                                empty_evt = 1'b1;
                                wk_d.st   = WK_IDLE;
                            end
                        end else begin
                            wk_d.plane = wk_q.plane + 2'd1;
                        end
                    end else begin
                        wk_d.word = wk_q.word + 1'b1;
                    end
                end
            end
            default: wk_d.st = WK_IDLE;
        endcase
        if (soft_rst) begin
            wk_d      = '0;
            ytr_evt   = 1'b0;
            empty_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign busy      = (wk_q.st == WK_RUN);
    assign req_valid = busy;
    assign req_addr  = cur_start + AW'({wk_q.word, 2'b00});
    assign req_plane = wk_q.plane;
    assign lane_le   = wk_q.le;
endmodule

// File: rtl/fas_status.sv
module fas_status
    import fas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ytr_evt,
    input  logic             empty_evt,
    input  logic             urun_evt,
    input  logic [NFLAG-1:0] clr,
    input  logic [1:0]       irq_en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } stat_t;

    stat_t st_q, st_d;
    logic [NFLAG-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[FL_YTR]   = ytr_evt;
        set_vec[FL_EMPTY] = empty_evt;
        set_vec[FL_URUN]  = urun_evt;
        st_d.flags        = (st_q.flags & ~clr) | set_vec;
        if (soft_rst) begin
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
    assign irq   = (st_q.flags[FL_YTR] & irq_en[0]) | (st_q.flags[FL_EMPTY] & irq_en[1]);
endmodule

// File: rtl/field_addr_seq.sv
module field_addr_seq
    import fas_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 11,
    parameter int WW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          fld_start,
    input  logic          ptr_load,
    input  logic [AW-1:0] y_base,
    input  logic [AW-1:0] u_base,
    input  logic [AW-1:0] v_base,
    input  logic [15:0]   y_stride,
    input  logic [15:0]   u_stride,
    input  logic [15:0]   v_stride,
    input  logic [LW-1:0] img_height,
    input  logic [WW-1:0] y_width,
    input  logic [WW-1:0] c_width,
    input  logic [LW-1:0] y_thresh,
    input  logic          le_sel,
    input  logic [2:0]    flag_clr,
    input  logic [1:0]    irq_en,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [1:0]    req_plane,
    output logic          lane_le,
    output logic          flag_ytr,
    output logic          flag_empty,
    output logic          flag_urun,
    output logic          irq
);
    logic [NPLANE-1:0][AW-1:0]   base_in;
    logic [NPLANE-1:0][STRW-1:0] stride_in;
    logic [NPLANE-1:0][AW-1:0]   sel_base;
    logic [NPLANE-1:0][STRW-1:0] act_stride;
    logic                        busy;
    logic                        field_go;
    logic                        ytr_evt;
    logic                        empty_evt;
    logic                        urun_evt;
    logic [NFLAG-1:0]            flags;

    assign base_in   = {v_base, u_base, y_base};
    assign stride_in = {v_stride, u_stride, y_stride};
    assign field_go  = fld_start & !busy & !soft_rst;

    fas_ptr_bank #(.AW(AW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .ptr_load   (ptr_load),
        .field_go   (field_go),
        .base_in    (base_in),
        .stride_in  (stride_in),
        .sel_base   (sel_base),
        .act_stride (act_stride),
        .urun_evt   (urun_evt)
    );

    fas_walker #(.AW(AW), .LW(LW), .WW(WW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .field_go   (field_go),
        .le_sel     (le_sel),
        .sel_base   (sel_base),
        .act_stride (act_stride),
        .height     (img_height),
        .y_thresh   (y_thresh),
        .y_width    (y_width),
        .c_width    (c_width),
        .req_ready  (req_ready),
        .busy       (busy),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_plane  (req_plane),
        .lane_le    (lane_le),
        .ytr_evt    (ytr_evt),
        .empty_evt  (empty_evt)
    );

    fas_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .ytr_evt   (ytr_evt),
        .empty_evt (empty_evt),
        .urun_evt  (urun_evt),
        .clr       (flag_clr),
        .irq_en    (irq_en),
        .flags     (flags),
        .irq       (irq)
    );

    assign flag_ytr   = flags[FL_YTR];
    assign flag_empty = flags[FL_EMPTY];
    assign flag_urun  = flags[FL_URUN];
endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_plane,
    input logic          lane_le,
    input logic          flag_ytr,
    input logic          flag_empty,
    input logic          flag_urun,
    input logic [2:0]    flag_clr,
    input logic [1:0]    irq_en,
    input logic          irq
);
    a_r1_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!req_valid && !flag_ytr && !flag_empty && !flag_urun));

    a_r2_plane_code: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_plane != 2'd3));

    a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !soft_rst) |=>
            (!req_valid || (req_plane != $past(req_plane)) ||
             (req_addr == $past(req_addr) + AW'(4))));

    a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !soft_rst) |=>
            (req_valid && $stable(req_addr) && $stable(req_plane)));

    a_r8_empty_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_empty) |-> !req_valid);

    a_r9_ytr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ytr && !flag_clr[0] && !soft_rst) |=> flag_ytr);

    a_r9_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_urun && !flag_clr[2] && !soft_rst) |=> flag_urun);

    a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_ytr && irq_en[0]) || (flag_empty && irq_en[1])) |-> irq);

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_ytr && !flag_empty) |-> !irq);

    a_r11_lane_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !soft_rst) |=> (!req_valid || $stable(lane_le)));
endmodule

bind field_addr_seq fas_checker #(.AW(AW)) u_fas_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_plane  (req_plane),
    .lane_le    (lane_le),
    .flag_ytr   (flag_ytr),
    .flag_empty (flag_empty),
    .flag_urun  (flag_urun),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/tb_field_addr_seq.sv
module tb_field_addr_seq;
    localparam int AW = 32;
    localparam int LW = 11;
    localparam int WW = 12;

    logic          clk = 1'b0;
    logic          rst_n, soft_rst, fld_start, ptr_load, le_sel, req_ready;
    logic [AW-1:0] y_base, u_base, v_base;
    logic [15:0]   y_stride, u_stride, v_stride;
    logic [LW-1:0] img_height, y_thresh;
    logic [WW-1:0] y_width, c_width;
    logic [2:0]    flag_clr;
    logic [1:0]    irq_en;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_plane;
    logic          lane_le, flag_ytr, flag_empty, flag_urun, irq;

    int n_chk  = 0;
    int n_fail = 0;
    int rcyc   = 0;

    always #4 clk = ~clk;

    field_addr_seq #(.AW(AW), .LW(LW), .WW(WW)) dut (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_ptrs(input logic [AW-1:0] yb, ub, vb, input logic [15:0] ys, us, vs);
        y_base = yb; u_base = ub; v_base = vb;
        y_stride = ys; u_stride = us; v_stride = vs;
        ptr_load = 1'b1;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic set_geom(input int h, yw, cw, th);
        img_height = LW'(h); y_width = WW'(yw); c_width = WW'(cw); y_thresh = LW'(th);
    endtask

    task automatic start_field();
        fld_start = 1'b1;
        @(negedge clk);
        fld_start = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 3'b000;
    endtask

    function automatic logic ready_of(input int mode, input int c);
        if (mode == 1) return (c % 3) != 2;
        if (mode == 2) return (c % 2) == 1;
        return 1'b1;
    endfunction

    // Walk the expected request stream of one field and compare each accepted request.
    task automatic run_field(input logic [AW-1:0] yb, ub, vb, input logic [15:0] ys, us, vs,
                             input int h, yw, cw, th, mode);
        int yn, cn;
        yn = (yw + 3) / 4; if (yn == 0) yn = 1;
        cn = (cw + 3) / 4; if (cn == 0) cn = 1;
        for (int l = 0; l < h; l++) begin
            for (int p = 0; p < 3; p++) begin
                int nw;
                logic [AW-1:0] b;
                logic [15:0] s;
                nw = (p == 0) ? yn : cn;
                b  = (p == 0) ? yb : ((p == 1) ? ub : vb);
                s  = (p == 0) ? ys : ((p == 1) ? us : vs);
                for (int k = 0; k < nw; k++) begin
                    logic [AW-1:0] ea;
                    bit taken;
                    int stall;
                    ea = b + AW'(l) * AW'(s) + AW'(k * 4);
                    taken = 1'b0;
                    stall = 0;
                    while (!taken) begin
                        if (req_valid) begin
                            req_ready = ready_of(mode, rcyc);
                            rcyc++;
                            if (req_ready) begin
                                check("R2/R4", "req_addr", 64'(req_addr), 64'(ea));
                                check("R2", "req_plane", 64'(req_plane), 64'(p));
                                taken = 1'b1;
                            end
                        end else begin
                            req_ready = 1'b0;
                            stall++;
                            if (stall > 50) begin
                                check("R2", "request missing", 64'(0), 64'(1));
                                return;
                            end
                        end
                        @(negedge clk);
                    end
                end
            end
            check("R7", "flag_ytr after line", 64'(flag_ytr),
                  64'((th != 0) && (l + 1 >= th)));
        end
        req_ready = 1'b0;
        check("R8", "flag_empty at field end", 64'(flag_empty), 64'(1));
        check("R8", "req_valid at field end", 64'(req_valid), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; fld_start = 1'b0; ptr_load = 1'b0;
        le_sel = 1'b0; req_ready = 1'b0; flag_clr = 3'b000; irq_en = 2'b00;
        y_base = '0; u_base = '0; v_base = '0;
        y_stride = '0; u_stride = '0; v_stride = '0;
        set_geom(1, 4, 4, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "req_valid after reset", 64'(req_valid), 64'(0));
        check("R1", "flags after reset", 64'({flag_ytr, flag_empty, flag_urun}), 64'(0));
        check("R10", "irq after reset", 64'(irq), 64'(0));

        // Field A: fresh pointers, big-endian, always ready
        set_geom(4, 10, 5, 2);
        load_ptrs(32'h1000, 32'h2000, 32'h3000, 16'h40, 16'h20, 16'h20);
        le_sel = 1'b0;
        start_field();
        check("R6", "flag_urun with fresh pointers", 64'(flag_urun), 64'(0));
        check("R11", "lane_le big-endian", 64'(lane_le), 64'(0));
        run_field(32'h1000, 32'h2000, 32'h3000, 16'h40, 16'h20, 16'h20, 4, 10, 5, 2, 0);

        // R10 / R9: interrupt combining and write-one-to-clear
        irq_en = 2'b01;
        @(negedge clk);
        check("R10", "irq from ytr", 64'(irq), 64'(1));
        clear_flags(3'b001);
        check("R9", "ytr cleared", 64'(flag_ytr), 64'(0));
        check("R9", "empty kept", 64'(flag_empty), 64'(1));
        check("R10", "irq with ytr clear, en ytr", 64'(irq), 64'(0));
        irq_en = 2'b10;
        @(negedge clk);
        check("R10", "irq from empty", 64'(irq), 64'(1));
        irq_en = 2'b00;
        @(negedge clk);
        check("R10", "irq disabled", 64'(irq), 64'(0));
        clear_flags(3'b111);
        check("R9", "all flags cleared", 64'({flag_ytr, flag_empty, flag_urun}), 64'(0));

        // R6: no reload, pointers reused, little-endian, stalling ready
        le_sel = 1'b1;
        start_field();
        le_sel = 1'b0;
        check("R6", "flag_urun without reload", 64'(flag_urun), 64'(1));
        check("R11", "lane_le little-endian", 64'(lane_le), 64'(1));
        run_field(32'h1000, 32'h2000, 32'h3000, 16'h40, 16'h20, 16'h20, 4, 10, 5, 2, 1);
        check("R11", "lane_le held after field", 64'(lane_le), 64'(1));
        clear_flags(3'b111);

        // Field B: wraparound, zero chroma width, threshold 0; mid-field load and start (R5, R12)
        set_geom(3, 4, 0, 0);
        load_ptrs(32'hFFFF_FFF0, 32'h8000_0000, 32'h0000_0100, 16'hFFFF, 16'h8000, 16'h0004);
        start_field();
        check("R6", "flag_urun field B", 64'(flag_urun), 64'(0));
        fork
            begin
                repeat (4) @(negedge clk);
                y_base = 32'h500; u_base = 32'h600; v_base = 32'h700;
                y_stride = 16'h8; u_stride = 16'h4; v_stride = 16'h4;
                ptr_load = 1'b1;
                fld_start = 1'b1;
                @(negedge clk);
                ptr_load = 1'b0;
                fld_start = 1'b0;
            end
        join_none
        run_field(32'hFFFF_FFF0, 32'h8000_0000, 32'h0000_0100, 16'hFFFF, 16'h8000, 16'h0004,
                  3, 4, 0, 0, 2);
        @(negedge clk);
        check("R12", "no field restarted by mid-field start", 64'(req_valid), 64'(0));
        clear_flags(3'b111);

        // Field C: pointers loaded during field B
        set_geom(5, 16, 8, 5);
        start_field();
        check("R5", "flag_urun after mid-field load", 64'(flag_urun), 64'(0));
        run_field(32'h500, 32'h600, 32'h700, 16'h8, 16'h4, 16'h4, 5, 16, 8, 5, 0);
        clear_flags(3'b111);

        // R1: soft reset mid-field discards a pending load
        start_field();
        check("R6", "flag_urun before soft reset", 64'(flag_urun), 64'(1));
        req_ready = 1'b1;
        repeat (3) @(negedge clk);
        load_ptrs(32'hA000, 32'hB000, 32'hC000, 16'h10, 16'h10, 16'h10);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        req_ready = 1'b0;
        check("R1", "req_valid after soft reset", 64'(req_valid), 64'(0));
        check("R1", "flags after soft reset", 64'({flag_ytr, flag_empty, flag_urun}), 64'(0));
        start_field();
        check("R1", "pending load discarded", 64'(flag_urun), 64'(1));
        run_field(32'h500, 32'h600, 32'h700, 16'h8, 16'h4, 16'h4, 5, 16, 8, 5, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule